// File: doc/BRIEF.md
# Descriptor Task Queue Sequencer

This block hands a series of jobs to a memory-to-memory processing engine. Software schedules a job by writing the address of its descriptor into a four-entry first-in first-out queue. The sequencer takes one address at a time. It reads the descriptor's first word through a synchronous memory read port and then launches the engine on that descriptor. Once the engine reports completion, the sequencer treats the word it read as a link to a further sub-task descriptor and repeats, until it reaches a zero link. Only then does it take the next queued address.

Two interrupt sources help software keep the queue supplied. The first, "drained", fires when a chain finishes and no task is waiting. The second, "room", fires when a slot is freed in a queue that was full. Each source has a sticky pending bit and an enable. A write made while the queue is full is thrown away and recorded in a sticky overflow flag. Status outputs report the queue occupancy and whether a job chain is in progress.

Top module: `dtq_sequencer`

## Requirements
- R1: `q_count` reports the number of queued addresses (0 to 4). It changes on the clock edge that samples an accepted write or a removal. Queued addresses leave in the order in which they were written.
- R2: A write sampled while `q_count` is 4 is discarded, even when a removal happens in the same cycle. From the next edge, `ovf_flag` reads 1 and stays set until a cycle with `ovf_clr` high and no new overflow.
- R3: An address is removed from the queue only while no chain is running, or in the cycle the last sub-task of the current chain completes. `mem_req` then stays high with `mem_addr` equal to the current descriptor address until `mem_valid` is sampled high.
- R4: The data word returned with `mem_valid` is the address of the next sub-task descriptor, and a value of zero ends the chain. The engine is launched on every descriptor of a chain in link order before the next queued task starts.
- R5: `eng_start` is a one-cycle pulse in the cycle after `mem_valid` was accepted, with `eng_addr` equal to the descriptor address. `eng_done` has an effect only while a launched descriptor is outstanding.
- R6: `busy` is high from the edge that removes an address from an idle sequencer until the edge that samples `eng_done` for the final descriptor of the last queued chain.
- R7: Bit 0 of `irq_pend` (drained) is set on the edge where a chain completes while the queue is empty.
- R8: Bit 1 of `irq_pend` (room) is set on the edge where an address is removed from a full queue.
- R9: A pending bit clears on a cycle with its `irq_clr` bit high and no new event; a new event wins over the clear. `irq` is high whenever a pending bit and its matching `irq_en` bit are both 1.
- R10: After reset, `q_count`, `busy`, `mem_req`, `eng_start`, `ovf_flag`, `irq_pend` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Write one descriptor address into the queue |
| push_addr | input | ADDR_W | Descriptor address to queue |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| irq_en | input | 2 | Interrupt enables (bit 0 drained, bit 1 room) |
| irq_clr | input | 2 | Write-one-to-clear for the pending bits |
| mem_req | output | 1 | Descriptor read request, held until valid |
| mem_addr | output | ADDR_W | Descriptor address being read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | ADDR_W | Descriptor word 0: next sub-task address |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_addr | output | ADDR_W | Descriptor address for the launch |
| eng_done | input | 1 | Engine completion pulse |
| irq | output | 1 | OR of the enabled pending bits |
| irq_pend | output | 2 | Sticky pending bits (bit 0 drained, bit 1 room) |
| ovf_flag | output | 1 | Sticky overflow status |
| q_count | output | 3 | Queue occupancy |
| busy | output | 1 | Chain processing in progress |

## Verification
Each result has a fixed delay after its stimulus. A queue write shows in `q_count` one edge later. A removal from an idle sequencer raises `mem_req` on that same edge. `eng_start` follows one edge after `mem_valid` is sampled. Pending bits and the overflow flag update on the edge that samples their cause, and `irq` follows the enables with no delay. A behavioural model advances on each rising edge from the same sampled inputs. All outputs are compared one time unit after that edge, so each output is checked in the cycle it is due. Directed checks at the falling edge confirm the overflow, clear, masking and reset cases.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_FETCH  = 2'd1,
      WK_LAUNCH = 2'd2,
      WK_WAIT   = 2'd3
   } walk_state_t;

   localparam int unsigned EVT_N       = 2;
   localparam int unsigned EVT_DRAINED = 0;
   localparam int unsigned EVT_ROOM    = 1;
endpackage

// File: rtl/dtq_addr_fifo.sv
module dtq_addr_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned WIDTH = 32,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic             ovf_clr,
   output logic [WIDTH-1:0] rd_data,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic             ovf
);
   logic [WIDTH-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             wr_ok, rd_ok;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_ptr_pow2
      assign wr_ptr_nx = wr_ptr + PTR_W'(1);
      assign rd_ptr_nx = rd_ptr + PTR_W'(1);
   end else begin : g_ptr_wrap
      assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (wr_ok) slot_q[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr_nx;
         if (rd_ok) rd_ptr <= rd_ptr_nx;
         unique case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
         ovf_q <= (ovf_q && !ovf_clr) || (wr_en && full);
      end
   end

   assign rd_data = slot_q[rd_ptr];
   assign count   = cnt_q;
   assign ovf     = ovf_q;

   a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full && !rd_en) |=> (count == CNT_W'($past(count) + CNT_W'(1))))
      else $error("R1: accepted write did not raise occupancy");

   a_r2_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> (count == $past(count)))
      else $error("R2: write to full queue changed occupancy");

   a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf)
      else $error("R2: overflow flag lost without clear");
endmodule

// File: rtl/dtq_chain_walker.sv
module dtq_chain_walker
   import dtq_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_empty,
   input  logic [AW-1:0] q_head,
   input  logic          mem_valid,
   input  logic [AW-1:0] mem_rdata,
   input  logic          eng_done,
   output logic          q_pop,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          eng_start,
   output logic [AW-1:0] eng_addr,
   output logic          busy,
   output logic          drained
);
   walk_state_t   st_q, st_d;
   logic [AW-1:0] cur_q, cur_d;
   logic [AW-1:0] link_q, link_d;
   logic          chain_last;

   assign chain_last = (link_q == '0);

   always_comb begin
      st_d    = st_q;
      cur_d   = cur_q;
      link_d  = link_q;
      q_pop   = 1'b0;
      drained = 1'b0;
      unique case (st_q)
         WK_IDLE: begin
            if (!q_empty) begin
               q_pop = 1'b1;
               cur_d = q_head;
               st_d  = WK_FETCH;
            end
         end
         WK_FETCH: begin
            if (mem_valid) begin
               link_d = mem_rdata;
               st_d   = WK_LAUNCH;
            end
         end
         WK_LAUNCH: st_d = WK_WAIT;
         WK_WAIT: begin
            if (eng_done) begin
               if (!chain_last) begin
                  cur_d = link_q;
                  st_d  = WK_FETCH;
               end else if (!q_empty) begin
                  q_pop = 1'b1;
                  cur_d = q_head;
                  st_d  = WK_FETCH;
               end else begin
                  drained = 1'b1;
                  st_d    = WK_IDLE;
               end
            end
         end
         default: st_d = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WK_IDLE;
         cur_q  <= '0;
         link_q <= '0;
      end else begin
         st_q   <= st_d;
         cur_q  <= cur_d;
         link_q <= link_d;
      end
   end

   assign mem_req   = (st_q == WK_FETCH);
   assign mem_addr  = cur_q;
   assign eng_start = (st_q == WK_LAUNCH);
   assign eng_addr  = cur_q;
   assign busy      = (st_q != WK_IDLE);

   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)))
      else $error("R3: read request dropped or address moved before valid");

   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start)
      else $error("R5: launch longer than one cycle");

   a_r5_start_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> $past(mem_req && mem_valid))
      else $error("R5: launch without a completed descriptor read");

   a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_done) |=> busy)
      else $error("R6: busy fell without engine completion");
endmodule

// File: rtl/dtq_irq_events.sv
module dtq_irq_events #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] en,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend,
   output logic         irq
);
   logic [N-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | ev;
   end

   assign pend = pend_q;
   assign irq  = |(pend_q & en);

   for (genvar gi = 0; gi < N; gi++) begin : g_src_chk
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         ev[gi] |=> pend[gi])
         else $error("R9: event did not set pending bit");

      a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[gi] && !ev[gi]) |=> !pend[gi])
         else $error("R9: pending bit survived clear");

      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[gi] && !clr[gi]) |=> pend[gi])
         else $error("R9: pending bit lost without clear");
   end
endmodule

// File: rtl/dtq_sequencer.sv
module dtq_sequencer
   import dtq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned QUEUE_DEPTH = 4,
   localparam int unsigned CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              ovf_clr,
   input  logic [EVT_N-1:0]  irq_en,
   input  logic [EVT_N-1:0]  irq_clr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              eng_start,
   output logic [ADDR_W-1:0] eng_addr,
   input  logic              eng_done,
   output logic              irq,
   output logic [EVT_N-1:0]  irq_pend,
   output logic              ovf_flag,
   output logic [CNT_W-1:0]  q_count,
   output logic              busy
);
   if (QUEUE_DEPTH < 2) begin : g_bad_depth
      $error("dtq_sequencer: QUEUE_DEPTH must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_width
      $error("dtq_sequencer: ADDR_W must be at least 2");
   end

   logic              q_pop, q_full, q_empty, drained;
   logic [ADDR_W-1:0] q_head;
   logic [EVT_N-1:0]  evt;

   dtq_addr_fifo #(.DEPTH(QUEUE_DEPTH), .WIDTH(ADDR_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_valid),
      .wr_data (push_addr),
      .rd_en   (q_pop),
      .ovf_clr (ovf_clr),
      .rd_data (q_head),
      .count   (q_count),
      .full    (q_full),
      .empty   (q_empty),
      .ovf     (ovf_flag)
   );

   dtq_chain_walker #(.AW(ADDR_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_empty   (q_empty),
      .q_head    (q_head),
      .mem_valid (mem_valid),
      .mem_rdata (mem_rdata),
      .eng_done  (eng_done),
      .q_pop     (q_pop),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .eng_start (eng_start),
      .eng_addr  (eng_addr),
      .busy      (busy),
      .drained   (drained)
   );

   always_comb begin
      evt              = '0;
      evt[EVT_DRAINED] = drained;
      evt[EVT_ROOM]    = q_pop && q_full;
   end

   dtq_irq_events #(.N(EVT_N)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (evt),
      .en    (irq_en),
      .clr   (irq_clr),
      .pend  (irq_pend),
      .irq   (irq)
   );

   a_r7_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend[EVT_DRAINED]) |-> !busy)
      else $error("R7: drained raised while a chain runs");

   a_r8_room_level: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend[EVT_ROOM]) |-> (q_count == CNT_W'(QUEUE_DEPTH - 1)))
      else $error("R8: room raised without a freed slot");
endmodule

// File: tb/tb_dtq_sequencer.sv
module tb_dtq_sequencer;
   import dtq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 32;
   localparam int DEPTH      = 4;

   logic          clk, rst_n;
   logic          push_valid, ovf_clr, mem_valid, eng_done;
   logic [AW-1:0] push_addr, mem_rdata;
   logic [1:0]    irq_en, irq_clr;
   logic          mem_req, eng_start, irq, ovf_flag, busy;
   logic [AW-1:0] mem_addr, eng_addr;
   logic [1:0]    irq_pend;
   logic [2:0]    q_count;

   dtq_sequencer #(.ADDR_W(AW), .QUEUE_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_addr(push_addr),
      .ovf_clr(ovf_clr), .irq_en(irq_en), .irq_clr(irq_clr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .eng_start(eng_start), .eng_addr(eng_addr), .eng_done(eng_done),
      .irq(irq), .irq_pend(irq_pend), .ovf_flag(ovf_flag), .q_count(q_count), .busy(busy)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;
   int mem_lat  = 0;
   int eng_lat  = 1;
   int spur_req = 0;

   logic [31:0] link_tbl [logic [31:0]];

   // behavioural reference state
   int          m_ph = 0;          // 0 idle, 1 reading, 2 launching, 3 engine running
   logic [31:0] m_cur = 0;
   logic [31:0] m_link = 0;
   logic [31:0] m_q [$];
   logic        m_ovf = 0;
   logic [1:0]  m_pend = 0;
   logic [31:0] exp_starts [$];

   initial begin
      clk = 0;
      forever #(CLK_PERIOD / 2) clk = ~clk;
   end

   function automatic logic [31:0] link_of(input logic [31:0] a);
      if (link_tbl.exists(a)) return link_tbl[a];
      return 32'h0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      bit full_now, drain_ev, room_ev;
      logic [31:0] a;
      if (!rst_n) begin
         m_ph = 0; m_cur = 0; m_link = 0; m_ovf = 0; m_pend = 0;
         m_q.delete();
         exp_starts.delete();
         return;
      end
      full_now = (m_q.size() == DEPTH);
      drain_ev = 0;
      room_ev  = 0;
      case (m_ph)
         0: if (m_q.size() != 0) begin
               m_cur = m_q.pop_front(); m_ph = 1; room_ev = full_now;
            end
         1: if (mem_valid) begin m_link = mem_rdata; m_ph = 2; end
         2: m_ph = 3;
         default: if (eng_done) begin
               if (m_link != 0) begin
                  m_cur = m_link; m_ph = 1;
               end else if (m_q.size() != 0) begin
                  m_cur = m_q.pop_front(); m_ph = 1; room_ev = full_now;
               end else begin
                  m_ph = 0; drain_ev = 1;
               end
            end
      endcase
      if (push_valid && !full_now) begin
         m_q.push_back(push_addr);
         a = push_addr;
         while (a != 0) begin
            exp_starts.push_back(a);
            a = link_of(a);
         end
      end
      m_ovf     = (m_ovf && !ovf_clr) || (push_valid && full_now);
      m_pend[0] = (m_pend[0] && !irq_clr[0]) || drain_ev;
      m_pend[1] = (m_pend[1] && !irq_clr[1]) || room_ev;
   endtask

   task automatic compare_all();
      chk("R1 q_count", 32'(q_count), 32'(m_q.size()));
      chk("R2 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
      chk("R3 mem_req", 32'(mem_req), 32'(m_ph == 1));
      if (m_ph == 1) chk("R3 R4 mem_addr", mem_addr, m_cur);
      chk("R5 eng_start", 32'(eng_start), 32'(m_ph == 2));
      if (m_ph == 2) begin
         chk("R5 eng_addr", eng_addr, m_cur);
         if (exp_starts.size() == 0) chk("R4 unexpected launch", eng_addr, 32'h0);
         else chk("R4 chain order", eng_addr, exp_starts.pop_front());
      end
      chk("R6 busy", 32'(busy), 32'(m_ph != 0));
      chk("R7 drained pending", 32'(irq_pend[0]), 32'(m_pend[0]));
      chk("R8 room pending", 32'(irq_pend[1]), 32'(m_pend[1]));
      chk("R9 irq", 32'(irq), 32'(|(m_pend & irq_en)));
   endtask

   always @(posedge clk) begin
      model_step();
      #1;
      if (!finished) compare_all();
   end

   // memory responder: answers mem_req after mem_lat extra cycles
   initial begin
      int wait_c;
      wait_c = -1;
      mem_valid = 0;
      mem_rdata = 0;
      forever begin
         @(negedge clk);
         mem_valid = 0;
         if (mem_req) begin
            if (wait_c < 0) wait_c = mem_lat;
            if (wait_c == 0) begin
               mem_valid = 1;
               mem_rdata = link_of(mem_addr);
               wait_c = -1;
            end else wait_c--;
         end
      end
   end

   // engine responder: completion eng_lat cycles after a launch
   initial begin
      int cnt_e, spur_ack;
      cnt_e = -1;
      spur_ack = 0;
      eng_done = 0;
      forever begin
         @(negedge clk);
         eng_done = 0;
         if (eng_start) cnt_e = eng_lat;
         else if (cnt_e > 0) cnt_e--;
         if (cnt_e == 0) begin
            eng_done = 1;
            cnt_e = -1;
         end else if (spur_req != spur_ack && cnt_e < 0 && !eng_start) begin
            eng_done = 1;
            spur_ack = spur_req;
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   task automatic push1(input logic [31:0] a);
      push_valid = 1; push_addr = a;
      @(negedge clk);
      push_valid = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || q_count != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=idle");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] burst [6];
      rst_n = 0; push_valid = 0; push_addr = 0; ovf_clr = 0; irq_en = 0; irq_clr = 0;
      link_tbl[32'h100] = 32'h0;
      link_tbl[32'h200] = 32'h240; link_tbl[32'h240] = 32'h280; link_tbl[32'h280] = 32'h0;
      link_tbl[32'h300] = 32'h340; link_tbl[32'h340] = 32'h0;
      link_tbl[32'h400] = 32'h0;
      link_tbl[32'h500] = 32'h540; link_tbl[32'h540] = 32'h580; link_tbl[32'h580] = 32'h0;
      link_tbl[32'h600] = 32'h0;
      link_tbl[32'h700] = 32'h0;
      link_tbl[32'h800] = 32'h840; link_tbl[32'h840] = 32'h0;
      link_tbl[32'h900] = 32'h940; link_tbl[32'h940] = 32'h0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset q_count", 32'(q_count), 0);
      chk("R10 reset busy", 32'(busy), 0);
      chk("R10 reset mem_req", 32'(mem_req), 0);
      chk("R10 reset eng_start", 32'(eng_start), 0);
      chk("R10 reset pending", 32'(irq_pend), 0);
      chk("R10 reset irq", 32'(irq), 0);
      chk("R10 reset ovf_flag", 32'(ovf_flag), 0);
      rst_n = 1;
      irq_en = 2'b11;
      @(negedge clk);

      // single task, no chain
      mem_lat = 0; eng_lat = 1;
      push1(32'h100);
      wait_idle();
      chk("R7 drained after single task", 32'(irq_pend[0]), 1);
      chk("R9 irq with drained enabled", 32'(irq), 1);
      irq_clr = 2'b01;
      @(negedge clk);
      irq_clr = 2'b00;
      chk("R9 drained cleared", 32'(irq_pend[0]), 0);

      // stray completion while idle has no effect
      spur_req++;
      repeat (3) @(negedge clk);
      chk("R5 stray done keeps idle", 32'(busy), 0);
      chk("R5 stray done no launch", 32'(eng_start), 0);
      chk("R7 stray done no drain", 32'(irq_pend[0]), 0);

      // three-descriptor chain with slow memory
      mem_lat = 3; eng_lat = 4;
      push1(32'h200);
      wait_idle();

      // burst that fills the queue and overflows it
      mem_lat = 1; eng_lat = 20;
      burst = '{32'h300, 32'h400, 32'h500, 32'h600, 32'h700, 32'h800};
      for (int i = 0; i < 6; i++) begin
         push_valid = 1; push_addr = burst[i];
         @(negedge clk);
      end
      push_valid = 0;
      chk("R1 queue full", 32'(q_count), 4);
      chk("R2 overflow flagged", 32'(ovf_flag), 1);
      ovf_clr = 1;
      @(negedge clk);
      ovf_clr = 0;
      chk("R2 overflow cleared", 32'(ovf_flag), 0);
      wait_idle();
      chk("R8 room after full queue drained", 32'(irq_pend[1]), 1);

      // masking
      irq_en = 2'b00;
      #1;
      chk("R9 irq masked", 32'(irq), 0);
      irq_en = 2'b10;
      #1;
      chk("R9 irq room enabled", 32'(irq), 1);
      irq_clr = 2'b11;
      @(negedge clk);
      irq_clr = 2'b00;
      chk("R9 all pending cleared", 32'(irq_pend), 0);
      irq_en = 2'b11;

      // spaced tasks, second written while the first runs
      mem_lat = 2; eng_lat = 2;
      push1(32'h900);
      repeat (3) @(negedge clk);
      push1(32'h600);
      wait_idle();
      chk("R4 every queued descriptor launched", 32'(exp_starts.size()), 0);

      finished = 1;
      summary();
      $finish;
   end
endmodule